// File: doc/BRIEF.md
# Full-Adder Reduction Delay Bound Checker

This unit decides early whether a set of signals, each with a known arrival time, could be reduced to a given number of output bits by a network of full adders within a target delay. It runs before any adder network is built, so a search for a reduction tree can discard a delay target that cannot work.

The unit uses the capacity function S(d). S(d) is the largest number of time-zero bits that one full-adder tree can fold into a single bit by delay d. It obeys S(0) = S(1) = 1 and S(d) = S(d-1) + 2·S(d-2). Each arrival time x has a weight of S(x). The target fails when the summed weight exceeds the out-bit count times S(target). It also fails when any arrival time is later than the target.

A session opens with a one-cycle `start` that carries the target delay and the out-bit count. Arrival times then stream in, one per cycle, under `in_valid`. The final one is tagged by `in_last`. The verdict comes back with a one-cycle strobe.

Top module: `adder_delay_bound`

## Requirements
- R1: While `rst` is high and after it falls, `verdict_done` and `verdict_ok` are 0 until the first verdict.
- R2: The capacity of delay d follows S(0)=S(1)=1 and S(d)=S(d-1)+2·S(d-2). This equals (2^(d+1)+(-1)^d)/3 for every d from 0 to 2^TW-1, with no truncation.
- R3: Weight W is the sum of S(x) over the accepted arrival times x, where each x is an unsigned TW-bit value. `verdict_ok` is 1 only when W ≤ `out_bits`·S(`tgt_delay`). The comparison is inclusive, so W equal to the limit is feasible.
- R4: If any accepted arrival time is greater than `tgt_delay`, `verdict_ok` is 0, whatever W is.
- R5: `start` clears the weight and the late flag and latches `tgt_delay` and `out_bits`. An `in_valid` beat in the same cycle as `start` is ignored.
- R6: Arrival beats while no session is open (after the last beat, before the next `start`) are ignored: no verdict, and no effect on the next session.
- R7: `verdict_done` is high for exactly one cycle, the cycle after the edge at which the `in_last` beat is accepted. `verdict_ok` is valid in that same cycle.
- R8: `verdict_ok` keeps its value until the next `verdict_done`.
- R9: The weight accumulator saturates at its all-ones value instead of wrapping. A very long stream therefore yields infeasible.
- R10: With `out_bits` = 0, every non-empty vector is infeasible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Opens a session; latches target and out-bit count |
| tgt_delay | input | TW | Target delay, unsigned |
| out_bits | input | KW | Number of bits the vector must reduce to |
| in_valid | input | 1 | Arrival-time beat valid |
| in_time | input | TW | Arrival time of one input signal |
| in_last | input | 1 | Marks the final beat of the vector |
| verdict_done | output | 1 | One-cycle verdict strobe |
| verdict_ok | output | 1 | 1 = target not ruled out, 0 = infeasible |

## Verification
The hardest conditions to reach from the ports are the exact-equality edge of the comparison at the widest capacity and saturation of the accumulator. The stimulus builds vectors whose weight equals out_bits·S(target) exactly, then adds a single time-zero input. It does this once at a small target and once at the largest target, where S(31) needs the full 32-bit table. A stream of several hundred beats at the maximum time pushes the accumulator to its all-ones value. Beats in the start cycle and between sessions are issued on purpose, and a cycle-level model in the bench shows they leave no trace.

// File: rtl/adb_pkg.sv
package adb_pkg;

    localparam int ADB_TW = 5;   // default arrival-time width
    localparam int ADB_KW = 6;   // default out-bit count width

    typedef enum logic {
        VERDICT_INFEASIBLE = 1'b0,
        VERDICT_FEASIBLE   = 1'b1
    } verdict_e;

    // capacity of delay 2^tw-1 stays below 2^(2^tw), so this many bits suffice
    function automatic int cap_bits(input int tw);
        return 2 ** tw;
    endfunction

endpackage

// File: rtl/adb_cap_table.sv
module adb_cap_table #(
    parameter int TW = adb_pkg::ADB_TW,
    parameter int CW = adb_pkg::cap_bits(TW)
) (
    input  logic [TW-1:0] sel_a,
    input  logic [TW-1:0] sel_b,
    output logic [CW-1:0] cap_a,
    output logic [CW-1:0] cap_b
);
    localparam int NT = 2 ** TW;

    logic [CW-1:0] cap [NT];

    // capacity chain built stage by stage from the two previous stages
    for (genvar d = 0; d < NT; d++) begin : g_stage
        if (d < 2) begin : g_seed
            assign cap[d] = CW'(1);
        end else begin : g_step
            assign cap[d] = cap[d-1] + {cap[d-2][CW-2:0], 1'b0};
        end
    end

    assign cap_a = cap[sel_a];
    assign cap_b = cap[sel_b];
endmodule

// File: rtl/adb_weight_acc.sv
module adb_weight_acc #(
    parameter int TW = adb_pkg::ADB_TW,
    parameter int CW = adb_pkg::cap_bits(TW),
    parameter int AW = CW + adb_pkg::ADB_KW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          add_en,
    input  logic [CW-1:0] add_val,
    input  logic [TW-1:0] t_in,
    input  logic [TW-1:0] t_lim,
    output logic [AW-1:0] weight_q,
    output logic          late_q,
    output logic [AW-1:0] weight_nx,
    output logic          late_nx
);
    logic [AW:0] sum_ext;

    assign sum_ext = {1'b0, weight_q} + (AW+1)'(add_val);

    always_comb begin
        weight_nx = weight_q;
        late_nx   = late_q;
        if (clr) begin
            weight_nx = '0;
            late_nx   = 1'b0;
        end else if (add_en) begin
            weight_nx = sum_ext[AW] ? {AW{1'b1}} : sum_ext[AW-1:0];
            if (t_in > t_lim) late_nx = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            weight_q <= '0;
            late_q   <= 1'b0;
        end else begin
            weight_q <= weight_nx;
            late_q   <= late_nx;
        end
    end
endmodule

// File: rtl/adb_verdict.sv
module adb_verdict #(
    parameter int CW = adb_pkg::cap_bits(adb_pkg::ADB_TW),
    parameter int KW = adb_pkg::ADB_KW,
    parameter int AW = CW + KW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fire,
    input  logic [AW-1:0] weight_nx,
    input  logic          late_nx,
    input  logic [CW-1:0] cap_tgt,
    input  logic [KW-1:0] k_q,
    output logic [CW+KW-1:0] limit,
    output logic          done_q,
    output logic          ok_q
);
    import adb_pkg::*;
    localparam int LW = CW + KW;

    verdict_e feas_d, feas_q;

    assign limit  = LW'(cap_tgt) * LW'(k_q);
    assign feas_d = (!late_nx && (weight_nx <= AW'(limit))) ? VERDICT_FEASIBLE
                                                             : VERDICT_INFEASIBLE;

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            feas_q <= VERDICT_INFEASIBLE;
        end else begin
            done_q <= fire;
            if (fire) feas_q <= feas_d;
        end
    end

    assign ok_q = (feas_q == VERDICT_FEASIBLE);
endmodule

// File: rtl/adder_delay_bound.sv
module adder_delay_bound #(
    parameter int TW = adb_pkg::ADB_TW,
    parameter int KW = adb_pkg::ADB_KW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [TW-1:0] tgt_delay,
    input  logic [KW-1:0] out_bits,
    input  logic          in_valid,
    input  logic [TW-1:0] in_time,
    input  logic          in_last,
    output logic          verdict_done,
    output logic          verdict_ok
);
    localparam int CW = adb_pkg::cap_bits(TW);
    localparam int AW = CW + KW + 1;

    typedef struct packed {
        logic          active;
        logic [TW-1:0] t;
        logic [KW-1:0] k;
    } session_t;

    session_t sess;
    logic accept, fire;
    logic [CW-1:0] cap_tgt, cap_in;
    logic [AW-1:0] weight, weight_nx;
    logic late, late_nx;
    logic [CW+KW-1:0] limit;

    assign accept = in_valid && sess.active && !start;
    assign fire   = accept && in_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            sess <= '0;
        end else if (start) begin
            sess.active <= 1'b1;
            sess.t      <= tgt_delay;
            sess.k      <= out_bits;
        end else if (fire) begin
            sess.active <= 1'b0;
        end
    end

    adb_cap_table #(.TW(TW), .CW(CW)) u_tab (
        .sel_a(sess.t),
        .sel_b(in_time),
        .cap_a(cap_tgt),
        .cap_b(cap_in)
    );

    adb_weight_acc #(.TW(TW), .CW(CW), .AW(AW)) u_acc (
        .clk(clk), .rst(rst),
        .clr(start), .add_en(accept), .add_val(cap_in),
        .t_in(in_time), .t_lim(sess.t),
        .weight_q(weight), .late_q(late),
        .weight_nx(weight_nx), .late_nx(late_nx)
    );

    adb_verdict #(.CW(CW), .KW(KW), .AW(AW)) u_ver (
        .clk(clk), .rst(rst), .fire(fire),
        .weight_nx(weight_nx), .late_nx(late_nx),
        .cap_tgt(cap_tgt), .k_q(sess.k),
        .limit(limit), .done_q(verdict_done), .ok_q(verdict_ok)
    );
endmodule

// File: rtl/adb_checker.sv
module adb_checker #(
    parameter int TW = 5,
    parameter int CW = 32,
    parameter int KW = 6,
    parameter int AW = CW + KW + 1
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          accept,
    input logic          in_last,
    input logic          active,
    input logic [TW-1:0] t_q,
    input logic [CW-1:0] cap_tgt,
    input logic [AW-1:0] weight,
    input logic          late,
    input logic [CW+KW-1:0] limit,
    input logic          done,
    input logic          ok
);
    function automatic logic [63:0] closed_cap(input logic [TW-1:0] d);
        logic [63:0] p;
        p = 64'd1 << (int'(d) + 1);
        return d[0] ? (p - 64'd1) / 64'd3 : (p + 64'd1) / 64'd3;
    endfunction

    a_r2_cap_closed_form: assert property (@(posedge clk) disable iff (rst)
        active |-> 64'(cap_tgt) == closed_cap(t_q));

    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r7_done_after_last: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(accept && in_last));

    a_r3_within_bound: assert property (@(posedge clk) disable iff (rst)
        (done && ok) |-> weight <= AW'(limit));

    a_r4_late_blocks: assert property (@(posedge clk) disable iff (rst)
        (done && late) |-> !ok);

    a_r5_clear_on_start: assert property (@(posedge clk) disable iff (rst)
        start |=> (weight == '0 && !late));

    a_r6_idle_no_accum: assert property (@(posedge clk) disable iff (rst)
        (!active && !start) |=> weight == $past(weight));

    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(ok));
endmodule

bind adder_delay_bound adb_checker #(.TW(TW), .CW(CW), .KW(KW), .AW(AW)) u_chk (
    .clk(clk), .rst(rst), .start(start), .accept(accept), .in_last(in_last),
    .active(sess.active), .t_q(sess.t), .cap_tgt(cap_tgt), .weight(weight),
    .late(late), .limit(limit), .done(verdict_done), .ok(verdict_ok)
);

// File: tb/tb_adder_delay_bound.sv
module tb_adder_delay_bound;
    localparam int TW = 5;
    localparam int KW = 6;

    logic clk = 1'b0, rst = 1'b1;
    logic start = 0, in_valid = 0, in_last = 0;
    logic [TW-1:0] tgt_delay = '0, in_time = '0;
    logic [KW-1:0] out_bits = '0;
    logic verdict_done, verdict_ok;

    int n_cmp = 0, n_bad = 0;
    string cur_req = "R1";
    bit armed = 0;
    int q[$];

    adder_delay_bound #(.TW(TW), .KW(KW)) dut (
        .clk(clk), .rst(rst), .start(start), .tgt_delay(tgt_delay),
        .out_bits(out_bits), .in_valid(in_valid), .in_time(in_time),
        .in_last(in_last), .verdict_done(verdict_done), .verdict_ok(verdict_ok)
    );

    always #4 clk = ~clk;

    function automatic longint ref_cap(input int d);
        longint p = longint'(1) << (d + 1);
        return (d % 2 == 1) ? (p - 1) / 3 : (p + 1) / 3;
    endfunction

    // behavioural reference, advanced on each rising edge
    bit m_done = 0, m_ok = 0, m_open = 0, m_late = 0;
    int m_t = 0, m_k = 0;
    longint m_w = 0;
    always @(posedge clk) begin
        if (rst) begin
            m_done = 0; m_ok = 0; m_open = 0; m_late = 0; m_w = 0;
        end else begin
            m_done = 0;
            if (start) begin
                m_open = 1; m_t = int'(tgt_delay); m_k = int'(out_bits);
                m_w = 0; m_late = 0;
            end else if (in_valid && m_open) begin
                m_w += ref_cap(int'(in_time));
                if (int'(in_time) > m_t) m_late = 1;
                if (in_last) begin
                    m_done = 1; m_open = 0;
                    m_ok = !m_late && (m_w <= longint'(m_k) * ref_cap(m_t));
                end
            end
        end
        armed = 1;
    end

    always @(negedge clk) begin
        if (armed) begin
            n_cmp++;
            if (verdict_done !== m_done || verdict_ok !== m_ok) begin
                n_bad++;
                $display("FAIL %s: done=%0b ok=%0b expected done=%0b ok=%0b",
                         cur_req, verdict_done, verdict_ok, m_done, m_ok);
            end
        end
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            start = 0; in_valid = 0; in_last = 0;
        end
    endtask

    task automatic open_sess(input int t, input int k, input bit junk);
        @(negedge clk);
        start = 1; tgt_delay = TW'(t); out_bits = KW'(k);
        in_valid = junk; in_time = '1; in_last = junk;   // R5: must be ignored
    endtask

    task automatic send_vec(input int t, input int k, input bit junk);
        open_sess(t, k, junk);
        foreach (q[i]) begin
            @(negedge clk);
            start = 0; in_valid = 1; in_time = TW'(q[i]);
            in_last = (i == q.size() - 1);
        end
        idle(3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_cmp++;
        if (verdict_done !== 1'b0 || verdict_ok !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: done=%0b ok=%0b expected 0/0", verdict_done, verdict_ok);
        end
        rst = 0;
        idle(2);

        cur_req = "R3"; q = '{3, 2, 2};       send_vec(4, 1, 0);  // weight 11 == limit
        cur_req = "R3"; q = '{3, 2, 2, 0};    send_vec(4, 1, 0);  // 12 > 11
        cur_req = "R8"; idle(4);
        cur_req = "R2"; q = '{30, 29, 29};    send_vec(31, 1, 0); // equals S(31)
        cur_req = "R2"; q = '{30, 29, 29, 0}; send_vec(31, 1, 0);
        cur_req = "R4"; q = '{4};             send_vec(3, 63, 0);
        cur_req = "R4"; q = '{0, 1, 3};       send_vec(3, 63, 0);
        cur_req = "R5"; q = '{1};             send_vec(2, 1, 1);
        cur_req = "R10"; q = '{0};            send_vec(5, 0, 0);
        cur_req = "R6";
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            in_valid = 1; in_time = 5'd31; in_last = (i == 3);
        end
        idle(3);
        q = '{2, 2}; send_vec(3, 1, 0);
        cur_req = "R7";
        open_sess(6, 2, 0);
        @(negedge clk); start = 0; in_valid = 1; in_time = 5'd6; in_last = 1;
        @(negedge clk); in_valid = 0; in_last = 0;
        open_sess(6, 2, 0);
        @(negedge clk); start = 0; in_valid = 1; in_time = 5'd5; in_last = 1;
        idle(3);
        cur_req = "R9";
        q = {};
        for (int i = 0; i < 400; i++) q.push_back(31);
        send_vec(31, 63, 0);
        cur_req = "R3";
        for (int s = 0; s < 60; s++) begin
            int t = $urandom_range(0, 31);
            int k = $urandom_range(0, 63);
            int n = $urandom_range(1, 12);
            q = {};
            for (int i = 0; i < n; i++) q.push_back($urandom_range(0, (t < 31) ? t + 1 : 31));
            send_vec(t, k, s[0]);
        end
        finish_run();
    end
endmodule